// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block is the error-status and ECC-mode word of a DRAM controller, reached through a single-cycle register write strobe and a combinational read port. The ECC datapath reports each detected error as a one-cycle pulse, one pulse line for correctable errors and one for uncorrectable errors. Each pulse carries the 4-bit chip-select row on which the error was seen.

The block keeps one sticky flag for each error kind. It also keeps a row field for each kind, which records the row of the first error after the flag was last clear. Software reads the word, handles the error, and then writes a 1 to the flag to re-arm it. Two per-kind enables decide which set flags raise the level output `err_signal`. The same word also holds the two-bit ECC operating mode and a diagnostic enable. Error pulses are ignored while the mode is off.

Top module: `ecc_status_reg`

## Requirements
- R1: After reset the read word is 0x00000000 and `err_signal` is low.
- R2: A `ue_pulse` sets bit 8 and captures `ue_row` into bits 7:4. A `ce_pulse` sets bit 9 and captures `ce_row` into bits 3:0. Both are visible on `reg_rdata` in the cycle after the clock edge that sampled the pulse.
- R3: A write with bit 8 (or bit 9) at 1 clears that flag. A write with the bit at 0 leaves the flag unchanged.
- R4: A row field is loaded only on a clock edge where its flag was 0 and an accepted pulse of that kind arrives. Later pulses of the same kind leave the row unchanged while the flag is set. Clearing the flag keeps the old row value until the next capture.
- R5: When an accepted pulse and a write-one-to-clear reach the same flag in one cycle, the flag stays set and its row field is not reloaded.
- R6: Bits 11:10 hold the ECC mode, encoded as 0 = off, 1 = detect only, 2 = correct, 3 = correct with scrub. Every write loads them from `reg_wdata[11:10]`, and they read back unchanged.
- R7: Every write loads bit 12 (diagnostic enable), bit 14 (uncorrectable signalling enable) and bit 15 (correctable signalling enable), and these bits read back unchanged.
- R8: Bits 31:16 and bit 13 always read as 0. Bits 7:0 cannot be written by software.
- R9: `err_signal` is high exactly while (bit 8 AND bit 14) OR (bit 9 AND bit 15) holds in the register.
- R10: While the mode field is 0, both error pulses are ignored and no flag or row changes.
- R11: Correctable and uncorrectable pulses arriving in the same cycle are each recorded independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register word |
| ue_pulse | input | 1 | Uncorrectable error event |
| ue_row | input | 4 | Chip-select row of the uncorrectable error |
| ce_pulse | input | 1 | Correctable error event |
| ce_row | input | 4 | Chip-select row of the correctable error |
| err_signal | output | 1 | Error signalling level |

## Verification
The whole state of the block is visible in `reg_rdata`, so a wrong flag, row or control bit appears on the read port one cycle after the edge that corrupted it. A wrong flag also shows on `err_signal` in that same cycle whenever its enable is set. Bugs that only affect the row, such as reloading it while the flag is set or reloading it when a pulse collides with a clear, stay hidden until a second error of that kind arrives. The bench therefore sends repeated and colliding pulses and compares the full word against a reference model on every cycle.

// File: rtl/ecc_status_pkg.sv
package ecc_status_pkg;

    localparam int ERR_KINDS = 2;
    localparam int KIND_UE   = 0;
    localparam int KIND_CE   = 1;

    // bit positions decoded by software
    localparam int POS_ROW_CE  = 0;
    localparam int POS_ROW_UE  = 4;
    localparam int POS_FLAG0   = 8;   // + kind index
    localparam int POS_MODE    = 10;
    localparam int POS_DIAG    = 12;
    localparam int POS_EN0     = 14;  // + kind index

    typedef enum logic [1:0] {
        ECC_OFF     = 2'd0,
        ECC_DETECT  = 2'd1,
        ECC_CORRECT = 2'd2,
        ECC_SCRUB   = 2'd3
    } ecc_mode_e;

    typedef struct packed {
        ecc_mode_e             mode;
        logic                  diag;
        logic [ERR_KINDS-1:0]  sig_en;
    } ctrl_t;

endpackage

// File: rtl/ecc_err_slot.sv
module ecc_err_slot #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             evt_i,
    input  logic [ROW_W-1:0] evt_row_i,
    input  logic             clr_i,
    input  logic             sig_en_i,
    output logic             flag_o,
    output logic [ROW_W-1:0] row_o,
    output logic             sig_o
);

    typedef struct packed {
        logic             flag;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d = st_q;
        take = evt_i & accept_i;
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (take) begin
            st_d.flag = 1'b1;
            if (!st_q.flag) begin
                st_d.row = evt_row_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign row_o  = st_q.row;
    assign sig_o  = st_q.flag & sig_en_i;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(evt_i && accept_i)) |=> !flag_o); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && accept_i) |=> flag_o); // R5

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> $stable(row_o)); // R4

    AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !flag_o) |=> (!flag_o && $stable(row_o))); // R10

endmodule

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
    import ecc_status_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [1:0]           mode_i,
    input  logic                 diag_i,
    input  logic [ERR_KINDS-1:0] en_i,
    output ctrl_t                ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d.mode   = ecc_mode_e'(mode_i);
            ctrl_d.diag   = diag_i;
            ctrl_d.sig_en = en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{mode: ECC_OFF, diag: 1'b0, sig_en: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ctrl_o.diag == $past(diag_i) && ctrl_o.sig_en == $past(en_i))); // R7

endmodule

// File: rtl/ecc_status_rdmux.sv
module ecc_status_rdmux
    import ecc_status_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  ctrl_t                             ctrl_i,
    input  logic [ERR_KINDS-1:0]              flag_i,
    input  logic [ERR_KINDS-1:0][ROW_W-1:0]   row_i,
    output logic [31:0]                       word_o
);

    always_comb begin
        word_o = '0;
        word_o[POS_ROW_CE +: ROW_W]     = row_i[KIND_CE];
        word_o[POS_ROW_UE +: ROW_W]     = row_i[KIND_UE];
        word_o[POS_FLAG0 +: ERR_KINDS]  = flag_i;
        word_o[POS_MODE +: 2]           = ctrl_i.mode;
        word_o[POS_DIAG]                = ctrl_i.diag;
        word_o[POS_EN0 +: ERR_KINDS]    = ctrl_i.sig_en;
    end

endmodule

// File: rtl/ecc_status_reg.sv
module ecc_status_reg
    import ecc_status_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             ue_pulse,
    input  logic [ROW_W-1:0] ue_row,
    input  logic             ce_pulse,
    input  logic [ROW_W-1:0] ce_row,
    output logic             err_signal
);

    ctrl_t                           ctrl;
    logic [ERR_KINDS-1:0]            evt_vec;
    logic [ERR_KINDS-1:0][ROW_W-1:0] evt_rows;
    logic [ERR_KINDS-1:0]            flags;
    logic [ERR_KINDS-1:0][ROW_W-1:0] rows;
    logic [ERR_KINDS-1:0]            sigs;
    logic                            accept;
    logic                            wdata_unused;

    assign wdata_unused = ^{reg_wdata[31:16], reg_wdata[13], reg_wdata[7:0]};

    always_comb begin
        evt_vec           = '0;
        evt_rows          = '0;
        evt_vec[KIND_UE]  = ue_pulse;
        evt_vec[KIND_CE]  = ce_pulse;
        evt_rows[KIND_UE] = ue_row;
        evt_rows[KIND_CE] = ce_row;
    end

    assign accept = (ctrl.mode != ECC_OFF);

    ecc_mode_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr),
        .mode_i (reg_wdata[POS_MODE +: 2]),
        .diag_i (reg_wdata[POS_DIAG]),
        .en_i   (reg_wdata[POS_EN0 +: ERR_KINDS]),
        .ctrl_o (ctrl)
    );

    for (genvar k = 0; k < ERR_KINDS; k++) begin : g_slot
        ecc_err_slot #(.ROW_W(ROW_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .accept_i  (accept),
            .evt_i     (evt_vec[k]),
            .evt_row_i (evt_rows[k]),
            .clr_i     (reg_wr & reg_wdata[POS_FLAG0 + k]),
            .sig_en_i  (ctrl.sig_en[k]),
            .flag_o    (flags[k]),
            .row_o     (rows[k]),
            .sig_o     (sigs[k])
        );
    end

    ecc_status_rdmux #(.ROW_W(ROW_W)) u_rdmux (
        .ctrl_i (ctrl),
        .flag_i (flags),
        .row_i  (rows),
        .word_o (reg_rdata)
    );

    assign err_signal = |sigs;

    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:16] == 16'h0 && reg_rdata[13] == 1'b0)); // R8

    AST_SIG_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        err_signal |-> (reg_rdata[9:8] != 2'b00)); // R9

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[11:10] == $past(reg_wdata[11:10]))); // R6

endmodule

// File: tb/tb_ecc_status_reg.sv
module tb_ecc_status_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ue_pulse = 1'b0;
    logic [3:0]  ue_row = '0;
    logic        ce_pulse = 1'b0;
    logic [3:0]  ce_row = '0;
    logic        err_signal;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model state
    logic [1:0] m_mode = 2'd0;
    logic       m_diag = 1'b0, m_enue = 1'b0, m_ence = 1'b0;
    logic       m_fue = 1'b0, m_fce = 1'b0;
    logic [3:0] m_rue = '0, m_rce = '0;

    always #5 clk = ~clk;

    ecc_status_reg dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ue_pulse(ue_pulse), .ue_row(ue_row),
        .ce_pulse(ce_pulse), .ce_row(ce_row), .err_signal(err_signal)
    );

    function automatic logic [31:0] cw(input logic [1:0] mode, input logic diag,
                                       input logic enue, input logic ence,
                                       input logic clrue, input logic clrce);
        return {16'h0, ence, enue, 1'b0, diag, mode, clrce, clrue, 8'h00};
    endfunction

    task automatic compare();
        logic [31:0] exp_w;
        logic        exp_s;
        exp_w = {16'h0, m_ence, m_enue, 1'b0, m_diag, m_mode, m_fce, m_fue, m_rue, m_rce};
        exp_s = (m_fue & m_enue) | (m_fce & m_ence);
        n_cmp++;
        if (reg_rdata !== exp_w) begin
            n_bad++;
            $display("FAIL %s rdata actual=%08h expected=%08h", cur_req, reg_rdata, exp_w);
        end
        n_cmp++;
        if (err_signal !== exp_s) begin
            n_bad++;
            $display("FAIL %s err_signal actual=%b expected=%b", cur_req, err_signal, exp_s);
        end
    endtask

    task automatic step(input logic w, input logic [31:0] wd,
                        input logic u, input logic [3:0] ur,
                        input logic c, input logic [3:0] cr);
        logic act, nu, nc;
        reg_wr = w; reg_wdata = wd;
        ue_pulse = u; ue_row = ur; ce_pulse = c; ce_row = cr;
        @(posedge clk);
        act = (m_mode != 2'd0);
        nu = m_fue;
        if (w && wd[8]) nu = 1'b0;
        if (u && act) begin nu = 1'b1; if (!m_fue) m_rue = ur; end
        nc = m_fce;
        if (w && wd[9]) nc = 1'b0;
        if (c && act) begin nc = 1'b1; if (!m_fce) m_rce = cr; end
        m_fue = nu; m_fce = nc;
        if (w) begin
            m_mode = wd[11:10]; m_diag = wd[12]; m_enue = wd[14]; m_ence = wd[15];
        end
        @(negedge clk);
        compare();
        reg_wr = 1'b0; ue_pulse = 1'b0; ce_pulse = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 1'b0, 4'h0, 1'b0, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
        idle();

        cur_req = "R10";
        step(1'b0, 0, 1'b1, 4'd3, 1'b1, 4'd6);
        idle();

        cur_req = "R6";
        step(1'b1, cw(2'd1, 0, 0, 0, 0, 0), 0, 0, 0, 0);
        step(1'b1, cw(2'd3, 0, 0, 0, 0, 0), 0, 0, 0, 0);
        step(1'b1, cw(2'd2, 0, 0, 0, 0, 0), 0, 0, 0, 0);

        cur_req = "R8";
        step(1'b1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step(1'b1, 32'hFFFF_20FF, 0, 0, 0, 0);

        cur_req = "R7";
        step(1'b1, cw(2'd2, 1, 1, 0, 0, 0), 0, 0, 0, 0);
        step(1'b1, cw(2'd2, 0, 0, 1, 0, 0), 0, 0, 0, 0);
        step(1'b1, cw(2'd3, 1, 1, 1, 0, 0), 0, 0, 0, 0);

        cur_req = "R2";
        step(1'b0, 0, 1'b1, 4'd5, 1'b0, 0);
        step(1'b0, 0, 1'b0, 0, 1'b1, 4'd2);

        cur_req = "R4";
        step(1'b0, 0, 1'b1, 4'd6, 1'b1, 4'd7);
        idle();

        cur_req = "R9";
        step(1'b1, cw(2'd3, 1, 0, 1, 0, 0), 0, 0, 0, 0);
        step(1'b1, cw(2'd3, 1, 1, 0, 0, 0), 0, 0, 0, 0);
        step(1'b1, cw(2'd3, 1, 0, 0, 0, 0), 0, 0, 0, 0);

        cur_req = "R3";
        step(1'b1, cw(2'd3, 1, 1, 1, 1, 0), 0, 0, 0, 0);
        step(1'b1, cw(2'd3, 1, 1, 1, 0, 0), 0, 0, 0, 0);
        step(1'b1, cw(2'd3, 1, 1, 1, 0, 1), 0, 0, 0, 0);

        cur_req = "R4";
        step(1'b0, 0, 1'b1, 4'd1, 1'b0, 0);

        cur_req = "R5";
        step(1'b1, cw(2'd3, 1, 1, 1, 1, 0), 1'b1, 4'd4, 1'b0, 0);
        step(1'b0, 0, 1'b0, 0, 1'b1, 4'd3);
        step(1'b1, cw(2'd3, 1, 1, 1, 0, 1), 1'b0, 0, 1'b1, 4'd0);
        idle();

        cur_req = "R11";
        step(1'b1, cw(2'd1, 0, 1, 1, 1, 1), 0, 0, 0, 0);
        step(1'b0, 0, 1'b1, 4'd7, 1'b1, 4'd6);

        cur_req = "R10";
        step(1'b1, cw(2'd0, 0, 1, 1, 1, 1), 0, 0, 0, 0);
        step(1'b0, 0, 1'b1, 4'd2, 1'b1, 4'd5);

        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            logic w;
            logic [31:0] wd;
            w  = ($urandom_range(0, 5) == 0);
            wd = $urandom();
            if (wd[11:10] == 2'd0 && $urandom_range(0, 3) != 0) wd[11:10] = 2'd2;
            step(w, wd, $urandom_range(0, 2) == 0, 4'($urandom_range(0, 7)),
                 $urandom_range(0, 2) == 0, 4'($urandom_range(0, 7)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule